// File: doc/BRIEF.md
# Register Pair and Stack Unit

This unit holds the six general byte registers of a classic 8-bit processor. It also holds a 16-bit stack pointer and a 16-bit program counter. The byte registers are grouped as three pairs: BC, DE and HL. An instruction decoder outside the unit issues one operation at a time. Most operations act on a whole pair as a single 16-bit quantity and finish in one clock. These are increment and decrement, the HL/DE swap, and copying HL into the stack pointer or the program counter.

Saving a pair to the stack, and restoring it, each take two byte-wide memory cycles. The memory port reads combinationally. The stack grows toward lower addresses. While a stack sequence runs, the unit reports itself busy and ignores new requests. It raises a one-cycle completion pulse once the stack pointer has been updated. Single byte registers can also be loaded one at a time from the decoder side. The general registers and the stack pointer carry no defined value after reset, so software loads them before use.

Top module: `rps_top`

## Requirements
- R1: While reset is asserted, and after it is released, the program counter reads 0000h, `busy` and `done` are low, and neither memory strobe is active.
- R2: With `wr_en` high, `op_valid` low and the unit idle, `wr_data` goes into the byte chosen by `wr_sel` (0=B, 1=C, 2=D, 3=E, 4=H, 5=L). The value is visible one clock later. Selects 6 and 7 change nothing.
- R3: An operation is accepted when `op_valid` is high and `busy` is low. Op code 1 adds one to the pair chosen by `pair_sel` and op code 2 subtracts one. The pair codes are 0=BC, 1=DE, 2=HL and 3=stack pointer. Both operations work on the pair as a 16-bit number and wrap modulo 65536.
- R4: Op code 3 exchanges D with H and E with L in one clock.
- R5: Op code 4 copies HL into the stack pointer and op code 5 copies HL into the program counter, each in one clock.
- R6: Op code 6 (push) performs two write cycles. The first writes the high byte of the pair to SP-1 and the second writes the low byte to SP-2. In the clock after the second write, SP reads SP-2 and `done` is high. Addresses wrap modulo 65536.
- R7: Op code 7 (pop) performs two read cycles. The first reads the low byte from SP and the second reads the high byte from SP+1. In the clock after the second read, the pair holds both bytes, SP reads SP+2 and `done` is high.
- R8: `busy` is high for the two memory cycles of a push or pop. While `busy` is high, operations and byte writes are ignored.
- R9: A push or pop with `pair_sel` = 3 is ignored. No strobe is raised, `busy` stays low and SP is unchanged.
- R10: `mem_we` and `mem_re` are never high together, and `done` never stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation code (R3 to R7) |
| pair_sel | input | 2 | Target pair: 0=BC, 1=DE, 2=HL, 3=SP |
| wr_en | input | 1 | Single-byte register write enable |
| wr_sel | input | 3 | Byte register select: 0=B to 5=L |
| wr_data | input | 8 | Byte register write value |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | One-cycle pulse when a push or pop completes |
| bc_q | output | 16 | Current BC pair |
| de_q | output | 16 | Current DE pair |
| hl_q | output | 16 | Current HL pair |
| sp_q | output | 16 | Current stack pointer |
| pc_q | output | 16 | Current program counter |

## Verification
Some properties are checked by assertions on every clock:
- the strobes never overlap;
- `done` is a single-cycle pulse;
- the second push cycle addresses one below the first, and the second pop cycle one above;
- the stack pointer moves by exactly two when a sequence completes;
- the program counter holds still while busy;
- an accepted BC increment shows up one clock later.

Other behaviour can only be shown by the bench scenarios. These cover the byte order of stored data, LIFO restore into a different pair, the swap, wrap-around at 0000h and FFFFh, and requests being ignored mid-sequence or for the stack-pointer pair code.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_XCHG = 3'd3,
    OP_SPHL = 3'd4,
    OP_PCHL = 3'd5,
    OP_PUSH = 3'd6,
    OP_POP  = 3'd7
  } rps_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_POP_LO  = 3'd3,
    ST_POP_HI  = 3'd4
  } rps_state_e;

  localparam int unsigned NUM_BYTE_REGS = 6;
  localparam logic [1:0]  PAIR_SP       = 2'd3;
endpackage

// File: rtl/rps_bank.sv
module rps_bank
  import rps_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          byte_we,
  input  logic [2:0]    byte_sel,
  input  logic [DW-1:0] byte_data,
  input  logic          pair_we,
  input  logic [1:0]    pair_idx,
  input  logic [PW-1:0] pair_val,
  input  logic          xchg,
  output logic [PW-1:0] bc_q,
  output logic [PW-1:0] de_q,
  output logic [PW-1:0] hl_q
);
  logic [DW-1:0] r_q [NUM_BYTE_REGS];
  logic [DW-1:0] r_d [NUM_BYTE_REGS];
  logic          upd;

  assign upd = byte_we | pair_we | xchg;

  always_comb begin
    for (int i = 0; i < NUM_BYTE_REGS; i++) r_d[i] = r_q[i];
    if (xchg) begin
      r_d[2] = r_q[4];
      r_d[3] = r_q[5];
      r_d[4] = r_q[2];
      r_d[5] = r_q[3];
    end else if (pair_we && (pair_idx != PAIR_SP)) begin
      r_d[{pair_idx, 1'b0}] = pair_val[PW-1:DW];
      r_d[{pair_idx, 1'b1}] = pair_val[DW-1:0];
    end
    if (byte_we && (byte_sel < 3'(NUM_BYTE_REGS))) r_d[byte_sel] = byte_data;
  end

  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (upd) r_q[g] <= r_d[g];
    end
  end

  assign bc_q = {r_q[0], r_q[1]};
  assign de_q = {r_q[2], r_q[3]};
  assign hl_q = {r_q[4], r_q[5]};
endmodule

// File: rtl/rps_ptrs.sv
module rps_ptrs #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_we,
  input  logic [PW-1:0] sp_nxt,
  input  logic          pc_we,
  input  logic [PW-1:0] pc_nxt,
  output logic [PW-1:0] sp_q,
  output logic [PW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (sp_we) sp_q <= sp_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_we) pc_q <= pc_nxt;
  end
endmodule

// File: rtl/rps_stack_fsm.sv
module rps_stack_fsm
  import rps_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_push,
  input  logic          start_pop,
  input  logic [1:0]    pair_idx,
  input  logic [PW-1:0] sp,
  input  logic [PW-1:0] push_val,
  output logic [1:0]    idx_q,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          pop_we,
  output logic [2:0]    pop_sel,
  output logic          sp_dec2,
  output logic          sp_inc2,
  output logic          busy,
  output logic          done
);
  rps_state_e state_q, state_d;
  logic       done_d;
  logic       idx_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_push)     state_d = ST_PUSH_HI;
        else if (start_pop) state_d = ST_POP_LO;
      end
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_POP_LO:  state_d = ST_POP_HI;
      default:    state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_PUSH_LO) || (state_q == ST_POP_HI);
    idx_en = (state_q == ST_IDLE) && (start_push || start_pop);
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_HI: begin mem_addr = sp - PW'(1); mem_wdata = push_val[PW-1:DW]; end
      ST_PUSH_LO: begin mem_addr = sp - PW'(2); mem_wdata = push_val[DW-1:0];  end
      ST_POP_LO:  mem_addr = sp;
      ST_POP_HI:  mem_addr = sp + PW'(1);
      default:    mem_addr = '0;
    endcase
  end

  assign mem_we  = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
  assign mem_re  = (state_q == ST_POP_LO)  || (state_q == ST_POP_HI);
  assign pop_we  = mem_re;
  assign pop_sel = {idx_q, state_q == ST_POP_LO};
  assign sp_dec2 = (state_q == ST_PUSH_LO);
  assign sp_inc2 = (state_q == ST_POP_HI);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (idx_en) idx_q <= pair_idx;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_PUSH_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) - PW'(1))); // R6
  AST_POP_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re) |=> (mem_re && mem_addr == $past(mem_addr) + PW'(1))); // R7
endmodule

// File: rtl/rps_top.sv
module rps_top
  import rps_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [1:0]    pair_sel,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] bc_q,
  output logic [PW-1:0] de_q,
  output logic [PW-1:0] hl_q,
  output logic [PW-1:0] sp_q,
  output logic [PW-1:0] pc_q
);
  logic          rst_meta, rst_sync;
  rps_op_e       op;
  logic          accept, is_sp;
  logic          do_inc, do_dec, do_xchg, do_sphl, do_pchl, do_push, do_pop;
  logic [PW-1:0] pair_cur, pair_step, push_val;
  logic [1:0]    fsm_idx;
  logic          pop_we, sp_dec2, sp_inc2, ext_wr;
  logic [2:0]    pop_sel, byte_sel;
  logic [DW-1:0] byte_data;
  logic          sp_we;
  logic [PW-1:0] sp_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    op      = rps_op_e'(op_code);
    accept  = op_valid && !busy;
    is_sp   = (pair_sel == PAIR_SP);
    do_inc  = accept && (op == OP_INC);
    do_dec  = accept && (op == OP_DEC);
    do_xchg = accept && (op == OP_XCHG);
    do_sphl = accept && (op == OP_SPHL);
    do_pchl = accept && (op == OP_PCHL);
    do_push = accept && (op == OP_PUSH) && !is_sp;
    do_pop  = accept && (op == OP_POP)  && !is_sp;
    unique case (pair_sel)
      2'd0:    pair_cur = bc_q;
      2'd1:    pair_cur = de_q;
      2'd2:    pair_cur = hl_q;
      default: pair_cur = sp_q;
    endcase
    pair_step = do_inc ? pair_cur + PW'(1) : pair_cur - PW'(1);
    unique case (fsm_idx)
      2'd0:    push_val = bc_q;
      2'd1:    push_val = de_q;
      default: push_val = hl_q;
    endcase
    ext_wr    = wr_en && !busy && !op_valid;
    byte_sel  = pop_we ? pop_sel : wr_sel;
    byte_data = pop_we ? mem_rdata : wr_data;
    sp_we     = ((do_inc || do_dec) && is_sp) || do_sphl || sp_dec2 || sp_inc2;
    if (sp_dec2)      sp_nxt = sp_q - PW'(2);
    else if (sp_inc2) sp_nxt = sp_q + PW'(2);
    else if (do_sphl) sp_nxt = hl_q;
    else              sp_nxt = pair_step;
  end

  rps_bank #(.DW(DW)) u_bank (
    .clk       (clk),
    .byte_we   (pop_we || ext_wr),
    .byte_sel  (byte_sel),
    .byte_data (byte_data),
    .pair_we   ((do_inc || do_dec) && !is_sp),
    .pair_idx  (pair_sel),
    .pair_val  (pair_step),
    .xchg      (do_xchg),
    .bc_q      (bc_q),
    .de_q      (de_q),
    .hl_q      (hl_q)
  );

  rps_ptrs #(.PW(PW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_sync),
    .sp_we  (sp_we),
    .sp_nxt (sp_nxt),
    .pc_we  (do_pchl),
    .pc_nxt (hl_q),
    .sp_q   (sp_q),
    .pc_q   (pc_q)
  );

  rps_stack_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync),
    .start_push (do_push),
    .start_pop  (do_pop),
    .pair_idx   (pair_sel),
    .sp         (sp_q),
    .push_val   (push_val),
    .idx_q      (fsm_idx),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .pop_we     (pop_we),
    .pop_sel    (pop_sel),
    .sp_dec2    (sp_dec2),
    .sp_inc2    (sp_inc2),
    .busy       (busy),
    .done       (done)
  );

  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && $past(mem_we)) |-> sp_q == $past(sp_q) - PW'(2)); // R6
  AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && $past(mem_re)) |-> sp_q == $past(sp_q) + PW'(2)); // R7
  AST_BUSY_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    busy |=> $stable(pc_q)); // R8
  AST_INC_BC: assert property (@(posedge clk) disable iff (!rst_sync)
    (op_valid && !busy && op_code == 3'd1 && pair_sel == 2'd0)
      |=> bc_q == $past(bc_q) + PW'(1)); // R3
endmodule

// File: tb/rps_top_tb.sv
module rps_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [1:0]  pair_sel;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] bc_q, de_q, hl_q, sp_q, pc_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
  } exp_t;
  exp_t sbq[$];

  logic [7:0] mem [256];

  always #10 clk = ~clk;

  rps_top u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .pair_sel(pair_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done),
    .bc_q(bc_q), .de_q(de_q), .hl_q(hl_q), .sp_q(sp_q), .pc_q(pc_q)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each memory cycle with the scoreboard
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      chk("R10 strobe exclusive", {31'd0, mem_we && mem_re}, 32'd0);
      if (sbq.size() == 0) begin
        chk("R6/R7 unexpected memory cycle", {16'd0, mem_addr}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk("R6/R7 cycle kind", {31'd0, mem_we}, {31'd0, e.wr});
        chk("R6/R7 cycle address", {16'd0, mem_addr}, {16'd0, e.addr});
        if (e.wr) chk("R6 write data", {24'd0, mem_wdata}, {24'd0, e.data});
      end
    end
  end

  task automatic wr_byte(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] code, input logic [1:0] p);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; pair_sel = p;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic push_seq(input logic [1:0] p, input logic [15:0] val, input logic [15:0] sp0);
    sbq.push_back('{1'b1, sp0 - 16'd1, val[15:8]});
    sbq.push_back('{1'b1, sp0 - 16'd2, val[7:0]});
    do_op(3'd6, p);
    chk("R8 busy in first push cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R6 done after push", {31'd0, done}, 32'd1);
    chk("R6 SP after push", {16'd0, sp_q}, {16'd0, sp0 - 16'd2});
    @(negedge clk);
    chk("R10 done single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic pop_seq(input logic [1:0] p, input logic [15:0] sp0);
    sbq.push_back('{1'b0, sp0, 8'h00});
    sbq.push_back('{1'b0, sp0 + 16'd1, 8'h00});
    do_op(3'd7, p);
    @(negedge clk);
    @(negedge clk);
    chk("R7 done after pop", {31'd0, done}, 32'd1);
    chk("R7 SP after pop", {16'd0, sp_q}, {16'd0, sp0 + 16'd2});
    @(negedge clk);
  endtask

  task automatic ignored_stack_op(input logic [2:0] code, input logic [15:0] sp0);
    do_op(code, 2'd3);
    for (int k = 0; k < 3; k++) begin
      chk("R9 no busy for SP pair", {31'd0, busy}, 32'd0);
      chk("R9 no strobe for SP pair", {30'd0, mem_we, mem_re}, 32'd0);
      @(negedge clk);
    end
    chk("R9 SP unchanged", {16'd0, sp_q}, {16'd0, sp0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; pair_sel = 2'd0;
    wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 PC in reset", {16'd0, pc_q}, 32'd0);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 PC after reset", {16'd0, pc_q}, 32'd0);
    chk("R1 idle flags", {29'd0, busy, done, mem_we || mem_re}, 32'd0);

    // R2 byte loads
    wr_byte(3'd0, 8'h12); wr_byte(3'd1, 8'hFF);
    wr_byte(3'd2, 8'h00); wr_byte(3'd3, 8'h00);
    wr_byte(3'd4, 8'h56); wr_byte(3'd5, 8'h78);
    chk("R2 BC", {16'd0, bc_q}, 32'h12FF);
    chk("R2 DE", {16'd0, de_q}, 32'h0000);
    chk("R2 HL", {16'd0, hl_q}, 32'h5678);
    wr_byte(3'd6, 8'hAA); wr_byte(3'd7, 8'hAA);
    chk("R2 unused select BC", {16'd0, bc_q}, 32'h12FF);
    chk("R2 unused select DE", {16'd0, de_q}, 32'h0000);
    chk("R2 unused select HL", {16'd0, hl_q}, 32'h5678);

    // R3 pair arithmetic with carry across bytes and wrap
    do_op(3'd1, 2'd0);
    chk("R3 INC BC carry", {16'd0, bc_q}, 32'h1300);
    do_op(3'd2, 2'd1);
    chk("R3 DEC DE wrap", {16'd0, de_q}, 32'hFFFF);
    do_op(3'd1, 2'd1);
    chk("R3 INC DE wrap", {16'd0, de_q}, 32'h0000);

    // R5 copies from HL
    do_op(3'd4, 2'd0);
    chk("R5 SP from HL", {16'd0, sp_q}, 32'h5678);
    do_op(3'd5, 2'd0);
    chk("R5 PC from HL", {16'd0, pc_q}, 32'h5678);

    // R4 exchange
    wr_byte(3'd2, 8'h9A); wr_byte(3'd3, 8'hBC);
    do_op(3'd3, 2'd0);
    chk("R4 DE after swap", {16'd0, de_q}, 32'h5678);
    chk("R4 HL after swap", {16'd0, hl_q}, 32'h9ABC);

    // R3 on the stack pointer
    do_op(3'd1, 2'd3);
    chk("R3 INC SP", {16'd0, sp_q}, 32'h5679);
    do_op(3'd2, 2'd3);
    chk("R3 DEC SP", {16'd0, sp_q}, 32'h5678);

    // R6 push with R8 interference during the sequence
    sbq.push_back('{1'b1, 16'h5677, 8'h13});
    sbq.push_back('{1'b1, 16'h5676, 8'h00});
    do_op(3'd6, 2'd0);
    chk("R8 busy during push", {31'd0, busy}, 32'd1);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    op_valid = 1'b1; op_code = 3'd1; pair_sel = 2'd0;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R6 done after push", {31'd0, done}, 32'd1);
    chk("R6 SP after push", {16'd0, sp_q}, 32'h5676);
    chk("R8 BC untouched while busy", {16'd0, bc_q}, 32'h1300);
    @(negedge clk);
    chk("R10 done single pulse", {31'd0, done}, 32'd0);

    push_seq(2'd2, 16'h9ABC, 16'h5676);

    // R7 pops restore in reverse order into other pairs
    pop_seq(2'd1, 16'h5674);
    chk("R7 DE from stack", {16'd0, de_q}, 32'h9ABC);
    pop_seq(2'd2, 16'h5676);
    chk("R7 HL from stack", {16'd0, hl_q}, 32'h1300);

    // R9 SP pair code ignored for stack operations
    ignored_stack_op(3'd6, 16'h5678);
    ignored_stack_op(3'd7, 16'h5678);

    // R6 address wrap below 0000h
    wr_byte(3'd4, 8'h00); wr_byte(3'd5, 8'h01);
    do_op(3'd4, 2'd0);
    push_seq(2'd1, 16'h9ABC, 16'h0001);
    pop_seq(2'd0, 16'hFFFF);
    chk("R7 BC across wrap", {16'd0, bc_q}, 32'h9ABC);

    repeat (2) @(negedge clk);
    chk("R6/R7 all memory cycles seen", sbq.size(), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule